// File: doc/BRIEF.md
# Synthesizer Register Write Interface over I2C

This block is an I2C target that sits in front of a frequency synthesizer's register set. It oversamples the bus lines with the system clock and answers one of three 7-bit device addresses. A two-bit strap input picks which address. It acknowledges by pulling SDA low through an open-drain enable. In write mode it sorts every data byte by its leading bit. A leading 0 opens a two-byte divider pair. A leading 1 is the control byte or, later in the same transfer, the band-port byte.

The divider word reaches the outputs only after both bytes of a pair have arrived. The control and port words are each updated at the end of their own byte. A single transfer can carry any number of groups, so several divider pairs can be sent back to back for a sweep without sending the address again. A STOP or a new START discards a group that is only half received, and every group latched before it keeps its value. A minimal read mode returns a status byte.

Top module: `i2c_synth_regif`

## Requirements
- R1: The device address is 0x60 when addr_sel is 00, 0x61 when it is 01, and 0x62 when it is 10 or 11. An address byte is seven address bits, MSB first, followed by a direction bit (0 = write, 1 = read). When the address matches, the block pulls SDA low during the ninth SCL clock.
- R2: When the address does not match, the block gives no acknowledge, and every further byte up to the next START is ignored, leaving all register outputs unchanged.
- R3: In a matched write transfer, every complete data byte is acknowledged in its ninth SCL clock.
- R4: A data byte with bit 7 = 0, arriving when no pair is open, opens a divider pair. div_word becomes {first[6:0], second[7:0]} once the second byte is complete, whatever the second byte's bit 7 is, and it stays unchanged between the two bytes.
- R5: A byte with bit 7 = 1 and no open pair is the control byte if it is the first such byte since the last START. It sets cp_high = bit 6, test_sel = bits 5:3, ref_sel = bits 2:1 and drive_off = bit 0. Any later such byte in the same transfer is a port byte and sets band_on = bits 3:0 (1 = on).
- R6: ref_ratio reports the crystal divide ratio selected by ref_sel: 00 gives 12, 01 gives 16, 10 gives 64, 11 gives 80.
- R7: A transfer may contain several divider pairs and other groups without repeating the address. Each pair updates div_word when it completes.
- R8: A STOP or START that arrives after only the first byte of a pair, or inside a byte, discards that partial group. Groups completed earlier keep their values.
- R9: A START or repeated START resets the byte-type tracking, so the next byte with bit 7 = 1 is again taken as a control byte.
- R10: In a matched read transfer, the block acknowledges the address and then sends the status byte {div_loaded, 3'b000, band_on}, MSB first. div_loaded is 1 once any divider pair has been latched since reset. The byte is sent again after each master ACK, and the block stops driving after a master NACK.
- R11: After reset, div_word, the control fields and band_on are all zero, ref_ratio is 12 and sda_pull is low.
- R12: sda_pull changes only while the synchronized SCL is low, and it is never active while the master shifts write data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel | input | 2 | Hardware strap choosing the device address |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain enable) |
| div_word | output | 15 | Programmable divider ratio |
| cp_high | output | 1 | Charge-pump high-current select |
| test_sel | output | 3 | Test-mode select |
| ref_sel | output | 2 | Reference divider select |
| ref_ratio | output | 7 | Crystal divide ratio decoded from ref_sel |
| drive_off | output | 1 | 1 = charge-pump drive amplifier off |
| band_on | output | 4 | Band port outputs, 1 = on |

## Verification
Each bus line passes through two synchronizer flops and one edge register. A completed byte therefore reaches the register outputs about four system clocks after its eighth SCL rise, and the acknowledge pull appears about four clocks after the eighth SCL fall. The bench holds every SCL phase for ten system clocks. It samples acknowledges and read bits in the middle of the SCL-high phase, and register outputs only after the byte's full ninth clock or after the STOP, well past the latency. The decode rules are modelled by a bench task fed with the same bytes, and the outputs are compared with that model.

// File: rtl/i2c_synth_pkg.sv
// Shared types for the synthesizer register interface.
// Assumes 8-bit I2C bytes and a 7-bit device address.
package i2c_synth_pkg;

    // Protocol phase of the byte engine.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_WR     = 3'd2,
        ST_ACK    = 3'd3,
        ST_RD     = 3'd4,
        ST_RDACK  = 3'd5,
        ST_IGNORE = 3'd6
    } synth_state_e;

    // Function-setting fields carried by the control byte.
    typedef struct packed {
        logic       cp_high;
        logic [2:0] test_sel;
        logic [1:0] ref_sel;
        logic       drive_off;
    } synth_ctrl_t;

    // Crystal divide ratio chosen by the reference select field.
    function automatic logic [6:0] ratio_of(input logic [1:0] sel);
        case (sel)
            2'b00:   ratio_of = 7'd12;
            2'b01:   ratio_of = 7'd16;
            2'b10:   ratio_of = 7'd64;
            default: ratio_of = 7'd80;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and derives
// SCL edges plus START and STOP conditions.
// Assumes each SCL phase lasts several system clocks; SYNC_STAGES >= 2.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic              scl_q;
    logic              sda_q;

    assign raw = {scl_i, sda_i};

    // One synchronizer chain per bus line.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe;
        // Shift the raw level through the flop chain; idle level is high.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = pipe[SYNC_STAGES-1];
    end

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_byte_engine.sv
// Bit-level I2C target: address compare, byte assembly, acknowledge
// generation and status byte transmission.
// Assumes clean edge and START/STOP pulses from i2c_line_sync.
module i2c_byte_engine
    import i2c_synth_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR0 = 7'h60,
    parameter logic [6:0] DEV_ADDR1 = 7'h61,
    parameter logic [6:0] DEV_ADDR2 = 7'h62,
    parameter int         BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        addr_sel,
    input  logic [BYTE_W-1:0] status_byte,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              frame_mark,
    output synth_state_e      state
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    synth_state_e      ret_state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              byte_full;
    logic              mst_ack;
    logic [6:0]        dev_addr;

    // Pick the device address from the hardware strap.
    always_comb begin
        case (addr_sel)
            2'b00:   dev_addr = DEV_ADDR0;
            2'b01:   dev_addr = DEV_ADDR1;
            default: dev_addr = DEV_ADDR2;
        endcase
    end

    // Protocol sequencer: receive, acknowledge and transmit bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ret_state  <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            txreg      <= '0;
            byte_full  <= 1'b0;
            mst_ack    <= 1'b0;
            sda_pull   <= 1'b0;
            rx_byte    <= '0;
            rx_valid   <= 1'b0;
            frame_mark <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            frame_mark <= 1'b0;
            if (stop_det) begin
                state      <= ST_IDLE;
                sda_pull   <= 1'b0;
                byte_full  <= 1'b0;
                frame_mark <= 1'b1;
            end else if (start_det) begin
                state      <= ST_ADDR;
                bitcnt     <= '0;
                byte_full  <= 1'b0;
                sda_pull   <= 1'b0;
                frame_mark <= 1'b1;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise && !byte_full) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) begin
                                byte_full <= 1'b1;
                                if (state == ST_WR) begin
                                    rx_byte  <= {shreg[BYTE_W-2:0], sda_s};
                                    rx_valid <= 1'b1;
                                end
                            end
                        end else if (scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            bitcnt    <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[BYTE_W-1:1] == dev_addr) begin
                                    sda_pull  <= 1'b1;
                                    state     <= ST_ACK;
                                    ret_state <= shreg[0] ? ST_RD : ST_WR;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else begin
                                sda_pull  <= 1'b1;
                                state     <= ST_ACK;
                                ret_state <= ST_WR;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            state  <= ret_state;
                            if (ret_state == ST_RD) begin
                                txreg    <= {status_byte[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~status_byte[BYTE_W-1];
                            end else begin
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_pull <= 1'b0;
                                state    <= ST_RDACK;
                            end else begin
                                sda_pull <= ~txreg[BYTE_W-1];
                                txreg    <= {txreg[BYTE_W-2:0], 1'b0};
                                bitcnt   <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RDACK: begin
                        if (scl_rise) begin
                            mst_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mst_ack) begin
                                bitcnt   <= '0;
                                txreg    <= {status_byte[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~status_byte[BYTE_W-1];
                                state    <= ST_RD;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_synth_cmd_decode.sv
// Sorts received write bytes into divider, control and port groups and
// latches each group when it is complete.
// Assumes rx_valid pulses once per byte and frame_mark marks START/STOP.
module i2c_synth_cmd_decode
    import i2c_synth_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int BAND_W = 4,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              frame_mark,
    output logic [DIV_W-1:0]  div_word,
    output synth_ctrl_t       ctrl,
    output logic [BAND_W-1:0] band_on,
    output logic              div_loaded
);
    localparam int HI_W = DIV_W - BYTE_W;

    logic [HI_W-1:0] hi_part;
    logic            pair_open;
    logic            ctrl_seen;

    // Classify each byte and latch complete groups; frame marks reset tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_part    <= '0;
            pair_open  <= 1'b0;
            ctrl_seen  <= 1'b0;
            div_word   <= '0;
            ctrl       <= '0;
            band_on    <= '0;
            div_loaded <= 1'b0;
        end else if (frame_mark) begin
            pair_open <= 1'b0;
            ctrl_seen <= 1'b0;
        end else if (rx_valid) begin
            if (pair_open) begin
                div_word   <= {hi_part, rx_byte};
                pair_open  <= 1'b0;
                div_loaded <= 1'b1;
            end else if (!rx_byte[BYTE_W-1]) begin
                hi_part   <= rx_byte[HI_W-1:0];
                pair_open <= 1'b1;
            end else if (!ctrl_seen) begin
                ctrl.cp_high   <= rx_byte[6];
                ctrl.test_sel  <= rx_byte[5:3];
                ctrl.ref_sel   <= rx_byte[2:1];
                ctrl.drive_off <= rx_byte[0];
                ctrl_seen      <= 1'b1;
            end else begin
                band_on <= rx_byte[BAND_W-1:0];
            end
        end
    end

endmodule

// File: rtl/i2c_synth_regif.sv
// Top level: I2C write interface for synthesizer registers.
// Assumes the SDA pad is open drain, enabled by sda_pull.
module i2c_synth_regif
    import i2c_synth_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR0   = 7'h60,
    parameter logic [6:0] DEV_ADDR1   = 7'h61,
    parameter logic [6:0] DEV_ADDR2   = 7'h62,
    parameter int         SYNC_STAGES = 2,
    parameter int         DIV_W       = 15,
    parameter int         BAND_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel,
    output logic              sda_pull,
    output logic [DIV_W-1:0]  div_word,
    output logic              cp_high,
    output logic [2:0]        test_sel,
    output logic [1:0]        ref_sel,
    output logic [6:0]        ref_ratio,
    output logic              drive_off,
    output logic [BAND_W-1:0] band_on
);
    localparam int BYTE_W = 8;
    localparam int PAD_W  = BYTE_W - 1 - BAND_W;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_valid, frame_mark, div_loaded;
    logic [BYTE_W-1:0] status_byte;
    synth_state_e      state;
    synth_ctrl_t       ctrl;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_byte_engine #(
        .DEV_ADDR0(DEV_ADDR0), .DEV_ADDR1(DEV_ADDR1), .DEV_ADDR2(DEV_ADDR2),
        .BYTE_W(BYTE_W)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .addr_sel(addr_sel), .status_byte(status_byte), .sda_pull(sda_pull),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .frame_mark(frame_mark),
        .state(state)
    );

    i2c_synth_cmd_decode #(.DIV_W(DIV_W), .BAND_W(BAND_W), .BYTE_W(BYTE_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .frame_mark(frame_mark), .div_word(div_word), .ctrl(ctrl),
        .band_on(band_on), .div_loaded(div_loaded)
    );

    // Status byte returned in read mode.
    assign status_byte = {div_loaded, {PAD_W{1'b0}}, band_on};

    // Unpack control fields onto the ports.
    assign cp_high   = ctrl.cp_high;
    assign test_sel  = ctrl.test_sel;
    assign ref_sel   = ctrl.ref_sel;
    assign drive_off = ctrl.drive_off;
    assign ref_ratio = ratio_of(ctrl.ref_sel);

endmodule

// File: rtl/i2c_synth_regif_chk.sv
// Protocol and register-update checks, bound into i2c_synth_regif.
module i2c_synth_regif_chk
    import i2c_synth_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int BAND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input synth_state_e      state,
    input logic              sda_pull,
    input logic              rx_valid,
    input logic [DIV_W-1:0]  div_word,
    input logic [6:0]        ctrl_bits,
    input logic [BAND_W-1:0] band_on,
    input logic [6:0]        ref_ratio
);
    // R12: the pull only moves while SCL is low
    p_pull_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !$past(scl_s));

    // R2: no pull when idle or ignoring the bus
    p_quiet_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_pull);

    // R3: received bytes are only delivered in write phase
    p_rx_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> state == ST_WR);

    // R4: divider moves only right after a byte was delivered
    p_div_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_word) |-> $past(rx_valid));

    // R5: control and band move only right after a byte was delivered
    p_ctrl_after_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ctrl_bits) || !$stable(band_on)) |-> $past(rx_valid));

    // R5: a byte updates at most one register group
    p_one_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!$stable(div_word), !$stable(ctrl_bits), !$stable(band_on)}));

    // R6: ratio is always one of the four legal values
    p_ratio_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ratio inside {7'd12, 7'd16, 7'd64, 7'd80});

endmodule

bind i2c_synth_regif i2c_synth_regif_chk #(.DIV_W(DIV_W), .BAND_W(BAND_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .state(state), .sda_pull(sda_pull),
    .rx_valid(rx_valid), .div_word(div_word),
    .ctrl_bits({cp_high, test_sel, ref_sel, drive_off}),
    .band_on(band_on), .ref_ratio(ref_ratio)
);

// File: tb/i2c_synth_regif_test.sv
`timescale 1ns/1ps
module i2c_synth_regif_test;
    localparam int H = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'b00;
    logic        sda_pull;
    logic [14:0] div_word;
    logic        cp_high, drive_off;
    logic [2:0]  test_sel;
    logic [1:0]  ref_sel;
    logic [6:0]  ref_ratio;
    logic [3:0]  band_on;
    wire         sda_bus = sda_m & ~sda_pull;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // expected model
    logic [14:0] m_div = '0;
    logic [6:0]  m_hi = '0;
    logic        m_pend = 0, m_ctrl_seen = 0, m_loaded = 0;
    logic        m_cp = 0, m_off = 0;
    logic [2:0]  m_test = '0;
    logic [1:0]  m_ref = '0;
    logic [3:0]  m_band = '0;

    always #2.5 clk = ~clk;

    i2c_synth_regif uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_sel(addr_sel), .sda_pull(sda_pull), .div_word(div_word),
        .cp_high(cp_high), .test_sel(test_sel), .ref_sel(ref_sel),
        .ref_ratio(ref_ratio), .drive_off(drive_off), .band_on(band_on)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_ratio(input logic [1:0] s);
        case (s)
            2'b00: return 7'd12;
            2'b01: return 7'd16;
            2'b10: return 7'd64;
            default: return 7'd80;
        endcase
    endfunction

    function automatic logic [6:0] addr_of(input logic [1:0] s);
        case (s)
            2'b00: return 7'h60;
            2'b01: return 7'h61;
            default: return 7'h62;
        endcase
    endfunction

    task automatic model_frame();
        m_pend = 0;
        m_ctrl_seen = 0;
    endtask

    task automatic model_byte(input logic [7:0] b);
        if (m_pend) begin
            m_div = {m_hi, b}; m_pend = 0; m_loaded = 1;
        end else if (!b[7]) begin
            m_hi = b[6:0]; m_pend = 1;
        end else if (!m_ctrl_seen) begin
            m_cp = b[6]; m_test = b[5:3]; m_ref = b[2:1]; m_off = b[0];
            m_ctrl_seen = 1;
        end else begin
            m_band = b[3:0];
        end
    endtask

    task automatic check_regs(input string req);
        chk(div_word == m_div, req, "div_word", div_word, m_div);
        chk({cp_high, test_sel, ref_sel, drive_off} == {m_cp, m_test, m_ref, m_off},
            req, "control", {cp_high, test_sel, ref_sel, drive_off},
            {m_cp, m_test, m_ref, m_off});
        chk(ref_ratio == exp_ratio(m_ref), "R6", "ref_ratio", ref_ratio, exp_ratio(m_ref));
        chk(band_on == m_band, req, "band_on", band_on, m_band);
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; hw(H);
        scl_m = 1; hw(H);
        sda_m = 0; hw(H);
        scl_m = 0; hw(H);
    endtask

    task automatic bus_stop();
        sda_m = 0; hw(H);
        scl_m = 1; hw(H);
        sda_m = 1; hw(2 * H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        bit pulled = 0;
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hw(H);
            if (sda_pull) pulled = 1;
            scl_m = 1; hw(H);
            scl_m = 0;
        end
        chk(!pulled, "R12", "pull during master data bits", pulled, 0);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1; hw(H);
        scl_m = 1; hw(H / 2);
        ack = ~sda_bus;
        hw(H / 2);
        scl_m = 0; hw(H);
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            hw(H);
            scl_m = 1; hw(H / 2);
            b[i] = sda_bus;
            hw(H / 2);
            scl_m = 0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; hw(H);
        scl_m = 1; hw(H);
        scl_m = 0; hw(H / 2);
        sda_m = 1; hw(H / 2);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<190000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        bit ack;
        logic [7:0] rb;
        void'($urandom(32'h5eed));
        hw(5);
        rst_n = 1; hw(4);

        // R11: reset state
        chk(sda_pull == 0, "R11", "sda_pull", sda_pull, 0);
        check_regs("R11");

        // R1, R3, R4: one divider pair with second byte MSB set
        bus_start(); model_frame();
        wr_byte({7'h60, 1'b0}, ack); chk(ack, "R1", "addr ack sel00", ack, 1);
        wr_byte(8'h12, ack); chk(ack, "R3", "data ack", ack, 1); model_byte(8'h12);
        chk(div_word == 15'h0, "R4", "div held mid pair", div_word, 0);
        wr_byte(8'hB4, ack); chk(ack, "R3", "data ack", ack, 1); model_byte(8'hB4);
        chk(div_word == 15'h12B4, "R4", "div pair", div_word, 15'h12B4);

        // R5: control then port in same transfer
        wr_byte(8'hED, ack); model_byte(8'hED);
        wr_byte(8'h8A, ack); model_byte(8'h8A);
        bus_stop(); model_frame();
        check_regs("R5");
        chk(ref_ratio == 7'd64, "R6", "ratio for 10", ref_ratio, 64);

        // R6: all four reference selections
        for (int s = 0; s < 4; s++) begin
            bus_start(); model_frame();
            wr_byte({7'h60, 1'b0}, ack);
            wr_byte({5'b10000, s[1:0], 1'b0}, ack); model_byte({5'b10000, s[1:0], 1'b0});
            bus_stop(); model_frame();
            chk(ref_ratio == exp_ratio(s[1:0]), "R6", "ratio sweep", ref_ratio, exp_ratio(s[1:0]));
        end

        // R7: sweep of three pairs in one transfer
        bus_start(); model_frame();
        wr_byte({7'h60, 1'b0}, ack);
        for (int p = 0; p < 3; p++) begin
            wr_byte(8'h20 + 8'(p), ack); model_byte(8'h20 + 8'(p));
            wr_byte(8'h11 * 8'(p + 1), ack); model_byte(8'h11 * 8'(p + 1));
            chk(div_word == m_div, "R7", "sweep step", div_word, m_div);
        end
        bus_stop(); model_frame();

        // R8: STOP after lone first byte keeps previous divider
        bus_start(); model_frame();
        wr_byte({7'h60, 1'b0}, ack);
        wr_byte(8'h7F, ack);
        bus_stop(); model_frame();
        check_regs("R8");
        // R8: STOP inside a byte
        bus_start(); model_frame();
        wr_byte({7'h60, 1'b0}, ack);
        send_bits(8'hFF, 4);
        bus_stop(); model_frame();
        check_regs("R8");

        // R9: repeated START resets tracking (next leading-1 byte is control)
        bus_start(); model_frame();
        wr_byte({7'h60, 1'b0}, ack);
        wr_byte(8'hC0, ack); model_byte(8'hC0);
        wr_byte(8'h05, ack); // lone first byte, discarded by repeated START
        bus_start(); model_frame();
        wr_byte({7'h60, 1'b0}, ack);
        wr_byte(8'hB3, ack); model_byte(8'hB3);
        bus_stop(); model_frame();
        check_regs("R9");

        // R2: wrong address for this strap is ignored
        addr_sel = 2'b01; hw(4);
        bus_start(); model_frame();
        wr_byte({7'h60, 1'b0}, ack); chk(!ack, "R2", "no ack on mismatch", ack, 0);
        wr_byte(8'h01, ack); chk(!ack, "R2", "no ack on data", ack, 0);
        wr_byte(8'h02, ack);
        wr_byte(8'hFF, ack);
        bus_stop(); model_frame();
        check_regs("R2");
        bus_start();
        wr_byte({7'h61, 1'b0}, ack); chk(ack, "R1", "addr ack sel01", ack, 1);
        bus_stop();
        addr_sel = 2'b11; hw(4);
        bus_start();
        wr_byte({7'h62, 1'b0}, ack); chk(ack, "R1", "addr ack sel11", ack, 1);
        bus_stop(); model_frame();

        // R10: read status twice, then NACK
        bus_start();
        wr_byte({7'h62, 1'b1}, ack); chk(ack, "R10", "read addr ack", ack, 1);
        rd_byte(1, rb);
        chk(rb == {m_loaded, 3'b000, m_band}, "R10", "status byte", rb, {m_loaded, 3'b000, m_band});
        rd_byte(0, rb);
        chk(rb == {m_loaded, 3'b000, m_band}, "R10", "status repeat", rb, {m_loaded, 3'b000, m_band});
        hw(H);
        chk(sda_pull == 0, "R10", "released after nack", sda_pull, 0);
        bus_stop();

        // random transfers against the model
        for (int t = 0; t < 40; t++) begin
            bit match;
            int n;
            logic [6:0] a;
            addr_sel = 2'($urandom % 4); hw(4);
            match = ($urandom % 5) != 0;
            a = match ? addr_of(addr_sel) : (addr_of(addr_sel) ^ 7'h04);
            n = 1 + int'($urandom % 6);
            bus_start(); model_frame();
            wr_byte({a, 1'b0}, ack);
            chk(ack == match, match ? "R1" : "R2", "random addr ack", ack, match);
            for (int k = 0; k < n; k++) begin
                logic [7:0] b;
                b = 8'($urandom);
                wr_byte(b, ack);
                chk(ack == match, match ? "R3" : "R2", "random data ack", ack, match);
                if (match) model_byte(b);
            end
            bus_stop(); model_frame();
            check_regs("R7");
        end

        finish_run();
    end
endmodule